// File: doc/BRIEF.md
# Configurable Asynchronous Serial Channel

This block is one full-duplex asynchronous serial channel. Software sets the framing and the speed through two control registers. It reads line and error conditions from an 8-bit status word. Transmit and receive share one holding-register address: a write queues a character for the transmitter, and the read port returns the last received character.

The channel has the following options:
- Character length of 5 to 8 bits.
- Optional parity, odd or even.
- One or two stop bits.
- A spacing (break) override on the output line.
- An internal loopback path.
- An auto-echo mode that sends each received character back out.
- Two modem-control outputs.

The transmit speed comes from an internal divider with eight rate codes, one of which selects an external 16x tick. The receiver either shares the transmit rate or runs from the fixed slowest internal rate, which allows split-speed links.

Top module: `serial_chan`

## Requirements
- R1: After reset, `status` is 8'h01, `txd` is 1, `hold_rdata` is 0, and `rts`/`dtr` are 0.
  - `rts` and `dtr` then follow control-1 bits 6 and 7.
  - Control-1 layout: bit0 normal (1 = line mode, 0 = loopback), bit1 break, bit2 single stop bit, bit3 auto-echo, bit4 parity enable, bit5 receiver enable, bit6 rts, bit7 dtr.
- R2: Control-2 bits [1:0] set the character length: 00 = 8, 01 = 7, 10 = 6, 11 = 5 bits.
  - Data is sent and received LSB first, after one low start bit.
  - Received bits above the length read as 0.
- R3: When parity is enabled, one parity bit follows the data. Control-2 bit2 selects the sense: 0 = odd, 1 = even.
  - A received parity mismatch sets status bit3.
- R4: Each transmitted frame ends in high stop bits: one when control-1 bit2 is 1, two when it is 0.
- R5: Control-2 bits [6:4] select the transmit rate. With a 16x base tick every BASE_DIV clocks, the bit period is 16·BASE_DIV clocks times the code's factor:
  - 100: ×1
  - 101: ×2
  - 110: ×4
  - 111 and 011: ×8
  - 010: ×32
  - 001: ×64
  - 000: the bit period is 16 pulses of `ext_tick`.
- R6: With control-2 bit3 = 1 the receiver uses the transmit rate. With bit3 = 0 it uses the ×64 rate.
- R7: With control-1 bit0 = 0, the transmitter output feeds the receiver and `txd` stays 1.
- R8: With auto-echo set, every received character is queued for transmission and sent on `txd`.
- R9: With break set in line mode, `txd` is 0. When break is cleared, the line returns to normal output.
- R10: A completed character sets status bit1 (data received) and stores the character.
  - A low first stop bit sets status bit4 (framing error).
  - A `hold_rd` pulse clears status bits 1 to 4.
- R11: A character completing while status bit1 is still set sets status bit2 (overrun) and replaces the stored character.
- R12: Status bit0 (holding empty) is 1 once the shifter has taken the character, even while that character is still being sent. It is 0 while a written character waits.
- R13: Status bit7 (data set change) sets when `dsr` or `cd` toggles while dtr is 1, or when `ri` toggles while dtr is 0. A `stat_rd` pulse clears it.
  - Status bits 6 and 5 show the synchronized `dsr` and `cd`.
- R14: With the receiver disabled (control-1 bit5 = 0), activity on the receive line completes no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wdata | input | 8 | Write data for the control and holding registers |
| ctl1_wr | input | 1 | Write strobe, control register 1 |
| ctl2_wr | input | 1 | Write strobe, control register 2 (bits 6:0) |
| hold_wr | input | 1 | Write strobe, transmit holding register |
| hold_rd | input | 1 | Read strobe for the received character; clears flags |
| stat_rd | input | 1 | Read strobe for status; clears data set change |
| hold_rdata | output | 8 | Last received character |
| status | output | 8 | Status flags |
| ext_tick | input | 1 | External 16x tick for rate code 000 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| dsr | input | 1 | Modem data-set-ready |
| cd | input | 1 | Modem carrier detect |
| ri | input | 1 | Modem ring indicator |
| rts | output | 1 | Modem request-to-send |
| dtr | output | 1 | Modem data-terminal-ready |

## Verification
A wrong internal state shows at the ports in different ways and at different speeds:
- A wrong frame build or bit counter shows within one character time. The bench decodes every frame on `txd` against a scoreboard and measures the start-to-start spacing of back-to-back frames, so a missing stop bit or a wrong rate code appears as a spacing error on the next frame.
- Receiver state errors show on the cycle after the stop bit is sampled, as wrong data or wrong flags in `status`.
- A wrong data-set-change trigger shows within a few cycles of a modem input toggle.

// File: rtl/serial_chan_pkg.sv
package serial_chan_pkg;

    typedef struct packed {
        logic dtr;
        logic rts;
        logic rx_en;
        logic par_en;
        logic echo;
        logic one_stop;
        logic brk;
        logic normal;
    } ctl1_t;

    typedef struct packed {
        logic [2:0] rate;
        logic       rx_same;
        logic       even;
        logic [1:0] len;
    } ctl2_t;

    function automatic logic [3:0] data_bits(input logic [1:0] len);
        return 4'd8 - {2'b00, len};
    endfunction

endpackage

// File: rtl/serial_baud.sv
module serial_baud #(
    parameter int BASE_DIV   = 1628,
    parameter int SLOW_SHIFT = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate,
    input  logic       rx_same,
    input  logic       ext_tick,
    output logic       tx_tick,
    output logic       rx_tick
);
    localparam int CW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam int PW = SLOW_SHIFT;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] pre;
    } st_t;

    st_t  s_d, s_q;
    logic t_base;
    int   sh;

    function automatic logic hit(input logic [PW-1:0] pre, input int shift);
        logic [PW-1:0] m;
        m = PW'((1 << shift) - 1);
        return (pre & m) == m;
    endfunction

    always_comb begin
        s_d    = s_q;
        t_base = (s_q.cnt == CW'(BASE_DIV - 1));
        if (t_base) begin
            s_d.cnt = '0;
            s_d.pre = s_q.pre + 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        case (rate)
            3'd1:       sh = SLOW_SHIFT;
            3'd2:       sh = SLOW_SHIFT - 1;
            3'd5:       sh = 1;
            3'd6:       sh = 2;
            3'd3, 3'd7: sh = 3;
            default:    sh = 0;
        endcase
        tx_tick = (rate == 3'd0) ? ext_tick : (t_base && hit(s_q.pre, sh));
        rx_tick = rx_same ? tx_tick : (t_base && hit(s_q.pre, SLOW_SHIFT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import serial_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic [1:0] len,
    input  logic       par_en,
    input  logic       even,
    input  logic       one_stop,
    output logic       line,
    output logic       empty
);
    typedef struct packed {
        logic [7:0]  hold;
        logic        full;
        logic        busy;
        logic [11:0] frame;
        logic [3:0]  left;
        logic [3:0]  sub;
    } st_t;

    st_t        s_d, s_q;
    logic [3:0] nb;

    function automatic logic [11:0] build(input logic [7:0] d, input logic [3:0] n,
                                          input logic pe, input logic ev);
        logic [11:0] f;
        logic        p;
        f    = '1;
        f[0] = 1'b0;
        p    = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (4'(i) < n) begin
                f[i+1] = d[i];
                p      = p ^ d[i];
            end
        end
        if (pe) f[n + 4'd1] = ev ? p : ~p;
        return f;
    endfunction

    always_comb begin
        s_d = s_q;
        nb  = data_bits(len);
        if (s_q.busy && tick) begin
            s_d.sub = s_q.sub + 1'b1;
            if (s_q.sub == 4'd15) begin
                s_d.frame = {1'b1, s_q.frame[11:1]};
                s_d.left  = s_q.left - 1'b1;
                if (s_q.left == 4'd1) s_d.busy = 1'b0;
            end
        end
        if (!s_d.busy && s_q.full) begin
            s_d.frame = build(s_q.hold, nb, par_en, even);
            s_d.left  = 4'd1 + nb + {3'b000, par_en} + (one_stop ? 4'd1 : 4'd2);
            s_d.sub   = '0;
            s_d.busy  = 1'b1;
            s_d.full  = 1'b0;
        end
        if (wr) begin
            s_d.hold = wdata;
            s_d.full = 1'b1;
        end
        line  = s_q.busy ? s_q.frame[0] : 1'b1;
        empty = ~s_q.full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_STOP_IS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.left == 4'd1) |-> line);  // R4
    AST_THRE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> (!s_q.full || $past(wr)));  // R12
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       line_in,
    input  logic [1:0] len,
    input  logic       par_en,
    input  logic       even,
    output logic       done,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    typedef struct packed {
        logic [1:0] sync;
        logic       act;
        logic [3:0] sub;
        logic [3:0] idx;
        logic [7:0] shf;
        logic       perr;
        logic       ferr;
        logic       done;
        logic [7:0] data;
    } st_t;

    st_t        s_d, s_q;
    logic       ln, exp_par;
    logic [3:0] nb;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.sync = {s_q.sync[0], line_in};
        ln       = s_q.sync[1];
        nb       = data_bits(len);
        exp_par  = even ? ^s_q.shf : ~^s_q.shf;
        if (!en) begin
            s_d.act = 1'b0;
        end else if (tick) begin
            if (!s_q.act) begin
                if (!ln) begin
                    s_d.act  = 1'b1;
                    s_d.sub  = '0;
                    s_d.idx  = '0;
                    s_d.shf  = '0;
                    s_d.perr = 1'b0;
                end
            end else begin
                s_d.sub = s_q.sub + 1'b1;
                if (s_q.idx == 4'd0) begin
                    if (s_q.sub == 4'd7) begin
                        if (ln) begin
                            s_d.act = 1'b0;
                        end else begin
                            s_d.idx = 4'd1;
                            s_d.sub = '0;
                        end
                    end
                end else if (s_q.sub == 4'd15) begin
                    s_d.idx = s_q.idx + 1'b1;
                    if (s_q.idx <= nb) begin
                        s_d.shf[3'(s_q.idx - 4'd1)] = ln;
                    end else if (par_en && s_q.idx == nb + 4'd1) begin
                        s_d.perr = (ln != exp_par);
                    end else begin
                        s_d.act  = 1'b0;
                        s_d.done = 1'b1;
                        s_d.data = s_q.shf;
                        s_d.ferr = ~ln;
                    end
                end
            end
        end
        done = s_q.done;
        data = s_q.data;
        perr = s_q.perr;
        ferr = s_q.ferr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sync <= 2'b11;
        end else begin
            s_q <= s_d;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);  // R10
    AST_RX_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !s_q.done);  // R14
endmodule

// File: rtl/serial_chan.sv
module serial_chan
    import serial_chan_pkg::*;
#(
    parameter int BASE_DIV = 1628
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] wdata,
    input  logic       ctl1_wr,
    input  logic       ctl2_wr,
    input  logic       hold_wr,
    input  logic       hold_rd,
    input  logic       stat_rd,
    output logic [7:0] hold_rdata,
    output logic [7:0] status,
    input  logic       ext_tick,
    input  logic       rxd,
    output logic       txd,
    input  logic       dsr,
    input  logic       cd,
    input  logic       ri,
    output logic       rts,
    output logic       dtr
);
    typedef struct packed {
        ctl1_t      c1;
        ctl2_t      c2;
        logic [7:0] rbuf;
        logic       rdy;
        logic       ovr;
        logic       perr;
        logic       ferr;
        logic       dsc;
        logic [2:0] ms1;
        logic [2:0] ms2;
        logic [2:0] mprev;
    } st_t;

    st_t        s_d, s_q;
    logic       tx_tick, rx_tick, tx_line, tx_empty, rx_line;
    logic       rx_done, rx_perr, rx_ferr, echo_ld, tx_wr;
    logic [7:0] rx_data, tx_data;
    logic [2:0] mchg;

    serial_baud #(.BASE_DIV(BASE_DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .rate(s_q.c2.rate), .rx_same(s_q.c2.rx_same),
        .ext_tick(ext_tick), .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    serial_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tx_tick), .wr(tx_wr), .wdata(tx_data),
        .len(s_q.c2.len), .par_en(s_q.c1.par_en), .even(s_q.c2.even),
        .one_stop(s_q.c1.one_stop), .line(tx_line), .empty(tx_empty)
    );

    serial_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(rx_tick), .en(s_q.c1.rx_en), .line_in(rx_line),
        .len(s_q.c2.len), .par_en(s_q.c1.par_en), .even(s_q.c2.even),
        .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
    );

    always_comb begin
        s_d       = s_q;
        s_d.ms1   = {dsr, cd, ri};
        s_d.ms2   = s_q.ms1;
        s_d.mprev = s_q.ms2;
        if (ctl1_wr) s_d.c1 = ctl1_t'(wdata);
        if (ctl2_wr) s_d.c2 = ctl2_t'(wdata[6:0]);
        mchg = s_q.ms2 ^ s_q.mprev;
        if (stat_rd) s_d.dsc = 1'b0;
        if (s_q.c1.dtr ? (mchg[2] | mchg[1]) : mchg[0]) s_d.dsc = 1'b1;
        if (hold_rd) begin
            s_d.rdy  = 1'b0;
            s_d.ovr  = 1'b0;
            s_d.perr = 1'b0;
            s_d.ferr = 1'b0;
        end
        if (rx_done) begin
            s_d.ovr  = s_d.ovr | (s_q.rdy & ~hold_rd);
            s_d.rdy  = 1'b1;
            s_d.rbuf = rx_data;
            s_d.perr = s_d.perr | rx_perr;
            s_d.ferr = s_d.ferr | rx_ferr;
        end
        echo_ld    = rx_done & s_q.c1.echo;
        tx_wr      = hold_wr | echo_ld;
        tx_data    = echo_ld ? rx_data : wdata;
        rx_line    = s_q.c1.normal ? rxd : tx_line;
        txd        = !s_q.c1.normal ? 1'b1 : (s_q.c1.brk ? 1'b0 : tx_line);
        rts        = s_q.c1.rts;
        dtr        = s_q.c1.dtr;
        hold_rdata = s_q.rbuf;
        status     = {s_q.dsc, s_q.ms2[2], s_q.ms2[1], s_q.ferr, s_q.perr,
                      s_q.ovr, s_q.rdy, tx_empty};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_RDY_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> s_q.rdy);  // R10
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_rd && !rx_done) |=> (!s_q.rdy && !s_q.ovr && !s_q.ferr));  // R10
    AST_OVR_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ovr) |-> $past(s_q.rdy));  // R11
    AST_ECHO_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && s_q.c1.echo) |=> !status[0]);  // R8
endmodule

// File: tb/serial_chan_test.sv
module serial_chan_test;
    logic       clk = 0, rst_n = 0;
    logic [7:0] wdata = 0;
    logic       ctl1_wr = 0, ctl2_wr = 0, hold_wr = 0, hold_rd = 0, stat_rd = 0;
    logic [7:0] hold_rdata, status;
    logic       ext_tick;
    logic       rxd = 1, txd, dsr = 0, cd = 0, ri = 0, rts, dtr;
    logic [1:0] ediv = 0;

    int checks = 0, fails = 0, cyc = 0, low_cnt = 0;
    int mon_p = 32, mon_n = 8;
    bit mon_pe = 0, mon_ev = 0, mon_on = 0;
    logic [7:0] exp_q[$];
    int starts[$];

    always #2 clk = ~clk;
    always @(posedge clk) begin
        cyc  <= cyc + 1;
        ediv <= ediv + 1'b1;
    end
    assign ext_tick = (ediv == 2'd3);
    always @(negedge clk) if (txd == 1'b0) low_cnt++;

    serial_chan #(.BASE_DIV(2)) uut (
        .clk(clk), .rst_n(rst_n), .wdata(wdata), .ctl1_wr(ctl1_wr), .ctl2_wr(ctl2_wr),
        .hold_wr(hold_wr), .hold_rd(hold_rd), .stat_rd(stat_rd), .hold_rdata(hold_rdata),
        .status(status), .ext_tick(ext_tick), .rxd(rxd), .txd(txd), .dsr(dsr), .cd(cd),
        .ri(ri), .rts(rts), .dtr(dtr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit par_of(input logic [7:0] d, input int n, input bit ev);
        bit x = 0;
        for (int i = 0; i < n; i++) x ^= d[i];
        return ev ? x : ~x;
    endfunction

    // Monitor: decodes txd frames and compares them with the scoreboard queue
    initial begin
        logic [7:0] got;
        logic [7:0] e;
        bit pb;
        forever begin
            @(negedge clk);
            if (mon_on && txd == 1'b0) begin
                starts.push_back(cyc);
                got = 0;
                repeat (mon_p / 2) @(negedge clk);
                for (int i = 0; i < mon_n; i++) begin
                    repeat (mon_p) @(negedge clk);
                    got[i] = txd;
                end
                if (mon_pe) begin
                    repeat (mon_p) @(negedge clk);
                    pb = txd;
                end
                repeat (mon_p) @(negedge clk);
                chk(txd == 1'b1, "R4 stop bit high", int'(txd), 1);
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected frame", got, 0);
                end else begin
                    e = exp_q.pop_front() & 8'((1 << mon_n) - 1);
                    chk(got == e, "R2 frame data", got, e);
                    if (mon_pe) chk(pb == par_of(e, mon_n, mon_ev), "R3 parity bit", pb, par_of(e, mon_n, mon_ev));
                end
            end
        end
    end

    task automatic bw1(input logic [7:0] d);
        wdata = d; ctl1_wr = 1; @(negedge clk); ctl1_wr = 0;
    endtask
    task automatic bw2(input logic [7:0] d);
        wdata = d; ctl2_wr = 1; @(negedge clk); ctl2_wr = 0;
    endtask
    task automatic rd_hold(output logic [7:0] v);
        v = hold_rdata; hold_rd = 1; @(negedge clk); hold_rd = 0;
    endtask
    task automatic tx_send(input logic [7:0] d);
        while (status[0] == 1'b0) @(negedge clk);
        wdata = d; hold_wr = 1; exp_q.push_back(d);
        @(negedge clk); hold_wr = 0;
    endtask
    task automatic wait_idle(input int p);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2 * p) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] d, input int n, input bit pe, input bit ev,
                           input int p, input bit bad_par, input bit bad_stop);
        bit par = 0;
        rxd = 0; repeat (p) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rxd = d[i]; par ^= d[i]; repeat (p) @(negedge clk);
        end
        if (pe) begin
            rxd = (ev ? par : ~par) ^ bad_par; repeat (p) @(negedge clk);
        end
        if (bad_stop) begin
            rxd = 0; repeat (3 * p / 4) @(negedge clk);
            rxd = 1; repeat (p + p / 4) @(negedge clk);
        end else begin
            rxd = 1; repeat (2 * p) @(negedge clk);
        end
    endtask

    task automatic run_tx(input logic [7:0] c1, input logic [7:0] c2, input int p, input int n,
                          input bit pe, input bit ev, input int nstop, input string tag);
        int sp;
        bw1(c1); bw2(c2);
        mon_p = p; mon_n = n; mon_pe = pe; mon_ev = ev; mon_on = 1;
        starts.delete();
        tx_send(8'hA5); tx_send(8'h3C); tx_send(8'h96);
        wait_idle(p);
        chk(starts.size() == 3, {tag, " frame count"}, starts.size(), 3);
        sp = (starts.size() == 3) ? starts[2] - starts[1] : 0;
        chk(sp == (1 + n + int'(pe) + nstop) * p, {tag, " frame spacing"}, sp, (1 + n + int'(pe) + nstop) * p);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=<190000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(status == 8'h01, "R1 status", status, 8'h01);
        chk(txd == 1'b1, "R1 txd idle", txd, 1);
        chk(hold_rdata == 8'h00, "R1 hold_rdata", hold_rdata, 0);
        chk({rts, dtr} == 2'b00, "R1 modem outputs", {rts, dtr}, 0);
        bw1(8'hE5);
        chk({rts, dtr} == 2'b11, "R1 modem outputs follow", {rts, dtr}, 3);

        // R4 stop bits, R2/R3 framing
        run_tx(8'hE5, 8'h48, 32, 8, 0, 0, 1, "R4 8N1");
        run_tx(8'hF1, 8'h4D, 32, 7, 1, 1, 2, "R4 7E2");
        // R5 rate codes
        run_tx(8'hE5, 8'h58, 64, 8, 0, 0, 1, "R5 code101");
        run_tx(8'hE5, 8'h08, 64, 8, 0, 0, 1, "R5 external");
        run_tx(8'hF5, 8'h6B, 128, 5, 1, 0, 1, "R5 code110 5O1");
        run_tx(8'hE5, 8'h28, 1024, 8, 0, 0, 1, "R5 code010");

        // R12 holding empty while still shifting
        bw2(8'h48); mon_p = 32; mon_n = 8; mon_pe = 0;
        tx_send(8'h5A);
        repeat (2) @(negedge clk);
        chk(status[0] == 1'b1, "R12 empty while sending", status[0], 1);
        chk(txd == 1'b0, "R12 shifter active", txd, 0);
        tx_send(8'h81);
        chk(status[0] == 1'b0, "R12 waiting char", status[0], 0);
        wait_idle(32);

        // R10 receive, R2 lengths, R3 parity
        send_rx(8'hC3, 8, 0, 0, 32, 0, 0);
        chk(status[1] == 1'b1, "R10 data received", status[1], 1);
        chk(hold_rdata == 8'hC3, "R2 rx 8-bit", hold_rdata, 8'hC3);
        rd_hold(v);
        chk(status[4:1] == 4'h0, "R10 read clears", status[4:1], 0);
        bw1(8'hF5); bw2(8'h4D);
        send_rx(8'h2B, 7, 1, 1, 32, 0, 0);
        chk(hold_rdata == 8'h2B && status[3] == 1'b0, "R3 good parity", {status[3], hold_rdata}, 8'h2B);
        rd_hold(v);
        send_rx(8'h2B, 7, 1, 1, 32, 1, 0);
        chk(status[3] == 1'b1, "R3 parity error", status[3], 1);
        rd_hold(v);
        bw1(8'hE5); bw2(8'h4B);
        send_rx(8'hFF, 5, 0, 0, 32, 0, 0);
        chk(hold_rdata == 8'h1F, "R2 rx 5-bit upper zero", hold_rdata, 8'h1F);
        rd_hold(v);
        bw2(8'h48);
        send_rx(8'h77, 8, 0, 0, 32, 0, 1);
        chk(status[4] == 1'b1, "R10 framing error", status[4], 1);
        rd_hold(v);
        chk(status[4] == 1'b0, "R10 framing cleared", status[4], 0);

        // R11 overrun
        send_rx(8'h11, 8, 0, 0, 32, 0, 0);
        send_rx(8'h22, 8, 0, 0, 32, 0, 0);
        chk(status[2] == 1'b1, "R11 overrun set", status[2], 1);
        chk(hold_rdata == 8'h22, "R11 newest kept", hold_rdata, 8'h22);
        rd_hold(v);
        chk(status[2] == 1'b0, "R11 overrun cleared", status[2], 0);

        // R14 receiver disabled
        bw1(8'hC5);
        send_rx(8'h44, 8, 0, 0, 32, 0, 0);
        chk(status[1] == 1'b0 && hold_rdata == 8'h22, "R14 disabled ignores", {status[1], hold_rdata}, 8'h22);
        bw1(8'hE5);

        // R6 split speed: receiver at x64 rate
        bw2(8'h40);
        send_rx(8'h6E, 8, 0, 0, 2048, 0, 0);
        chk(status[1] == 1'b1 && hold_rdata == 8'h6E, "R6 split-speed rx", {status[1], hold_rdata}, 9'h16E);
        rd_hold(v);
        bw2(8'h48);

        // R7 loopback
        mon_on = 0;
        bw1(8'hE4);
        low_cnt = 0;
        wdata = 8'h9D; hold_wr = 1; @(negedge clk); hold_wr = 0;
        repeat (12 * 32 + 60) @(negedge clk);
        chk(hold_rdata == 8'h9D && status[1], "R7 loopback data", hold_rdata, 8'h9D);
        chk(low_cnt == 0, "R7 txd held high", low_cnt, 0);
        rd_hold(v);

        // R8 auto-echo
        bw1(8'hED); mon_on = 1; mon_p = 32; mon_n = 8; mon_pe = 0;
        exp_q.push_back(8'h4E);
        send_rx(8'h4E, 8, 0, 0, 32, 0, 0);
        wait_idle(32);
        chk(exp_q.size() == 0, "R8 echo sent", exp_q.size(), 0);
        rd_hold(v);
        chk(v == 8'h4E, "R8 echo char received", v, 8'h4E);

        // R9 break
        mon_on = 0;
        bw1(8'hE7);
        repeat (3) @(negedge clk);
        chk(txd == 1'b0, "R9 break spacing", txd, 0);
        bw1(8'hE5);
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R9 break released", txd, 1);

        // R13 data set change (dtr = 1 now)
        ri = 1; repeat (6) @(negedge clk);
        chk(status[7] == 1'b0, "R13 ri ignored with dtr", status[7], 0);
        cd = 1; repeat (6) @(negedge clk);
        chk(status[7] == 1'b1 && status[5] == 1'b1, "R13 cd change", status[7:5], 3'b101);
        stat_rd = 1; @(negedge clk); stat_rd = 0;
        chk(status[7] == 1'b0, "R13 cleared", status[7], 0);
        bw1(8'h65);
        chk(dtr == 1'b0, "R1 dtr low", dtr, 0);
        dsr = 1; repeat (6) @(negedge clk);
        chk(status[7] == 1'b0 && status[6] == 1'b1, "R13 dsr ignored without dtr", status[7:6], 2'b01);
        ri = 0; repeat (6) @(negedge clk);
        chk(status[7] == 1'b1, "R13 ri change", status[7], 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule